// File: doc/BRIEF.md
# Rate-Counter ADSR Envelope Generator

This block produces an 8-bit amplitude envelope for one synthesizer voice. A gate input starts and ends a note. Four 4-bit controls set the attack, decay and release speeds and the sustain level. A free-running 15-bit rate counter sets when the envelope may move. The counter tests for equality against a period chosen by the rate control of the active stage. The envelope rises in equal unit steps during attack. During decay and release a second divider stretches the steps, and the amount of stretch depends on the present level. The fall is therefore roughly exponential.

The rate counter is never cleared when the gate changes, and it only matches on equality. This keeps a well-known quirk. If a rate control is lowered below the counter's present value, the counter runs all the way to its top, wraps to zero, and only then reaches the new period. Gate patterns that are faster than the rate period also build up because of this: attack and release share one counter phase. Every register advances only in cycles where `tick_en` is high.

Top module: `env_shaper`

## Requirements
- R1: While and after reset, `env_o` is 0 and the block is in its release stage with both dividers at zero. With the gate low it stays at 0.
- R2: In a stage, the rate counter gives one step opportunity every P enabled cycles, where P comes from that stage's rate control (values 0 to 15 map to 9, 32, 63, 95, 149, 220, 267, 313, 392, 977, 1954, 3126, 3907, 11720, 19532, 31251).
- R3: The rate counter counts modulo 2^15 and matches only when its incremented value equals P. If P is lowered below the count, no step happens until the counter has wrapped through 0x7FFF and climbed to P again.
- R4: Gate changes never clear or reload the rate counter. They change only which rate control and direction apply.
- R5: In attack, every rate match raises `env_o` by exactly 1, with no extra division.
- R6: When attack brings `env_o` to 0xFF, the block enters decay on that same step. The next steps with the gate held high lower the level.
- R7: In decay and release, a level step takes N rate matches. N is 1 above 0x5D, 2 for 0x36–0x5D, 4 for 0x1A–0x35, 8 for 0x0E–0x19, 16 for 0x06–0x0D and 30 for 0x00–0x05.
- R8: Decay stops at the sustain control copied into both nibbles (control × 0x11), and that level holds while the gate stays high.
- R9: A rising gate enters attack and a falling gate enters release, from any stage. The change takes effect from the next enabled cycle.
- R10: The level never goes below 0. Once 0 is reached in decay or release it stays there until an attack begins.
- R11: In cycles with `tick_en` low, no state changes: the envelope, counters, stage and sampled gate all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advance enable; all state moves only when high |
| gate | input | 1 | Note gate; rising starts attack, falling starts release |
| atk_rate | input | 4 | Attack rate control |
| dcy_rate | input | 4 | Decay rate control |
| sus_level | input | 4 | Sustain level control (target = value × 0x11) |
| rel_rate | input | 4 | Release rate control |
| env_o | output | 8 | Envelope level |

## Verification
The hardest state to reach from the ports is the wrap-around delay. The rate counter has to be sitting above a newly chosen period, and only the counter's history puts it there. The stimulus holds a slow release setting for 150 enabled cycles, so the count climbs to about 150. It then switches to the fastest period and raises the gate. The level must stay at zero for more than 32,000 cycles and then start to rise. Gate toggling faster than the rate period, and checks of the step interval inside each curve band, are compared against a reference model that runs every cycle.

// File: rtl/env_shaper_pkg.sv
package env_shaper_pkg;

   localparam int LVL_W   = 8;
   localparam int RATE_MIN_W = 15;
   localparam int CURVE_MIN_W = 5;

   typedef enum logic [1:0] {
      STG_ATTACK  = 2'd0,
      STG_DECAY   = 2'd1,
      STG_RELEASE = 2'd2
   } stage_e;

   // Enabled cycles between rate matches for each rate control value.
   function automatic logic [RATE_MIN_W-1:0] rate_period(input logic [3:0] sel);
      logic [RATE_MIN_W-1:0] p;
      unique case (sel)
         4'h0: p = 15'd9;
         4'h1: p = 15'd32;
         4'h2: p = 15'd63;
         4'h3: p = 15'd95;
         4'h4: p = 15'd149;
         4'h5: p = 15'd220;
         4'h6: p = 15'd267;
         4'h7: p = 15'd313;
         4'h8: p = 15'd392;
         4'h9: p = 15'd977;
         4'hA: p = 15'd1954;
         4'hB: p = 15'd3126;
         4'hC: p = 15'd3907;
         4'hD: p = 15'd11720;
         4'hE: p = 15'd19532;
         default: p = 15'd31251;
      endcase
      return p;
   endfunction

   // Rate matches per level step while falling, by level band.
   function automatic logic [CURVE_MIN_W-1:0] curve_period(input logic [LVL_W-1:0] lvl);
      logic [CURVE_MIN_W-1:0] n;
      if (lvl > 8'h5D)       n = 5'd1;
      else if (lvl >= 8'h36) n = 5'd2;
      else if (lvl >= 8'h1A) n = 5'd4;
      else if (lvl >= 8'h0E) n = 5'd8;
      else if (lvl >= 8'h06) n = 5'd16;
      else                   n = 5'd30;
      return n;
   endfunction

endpackage

// File: rtl/env_rate_div.sv
module env_rate_div #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             hit_o,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             match;

   assign cnt_inc = cnt_q + CNT_W'(1);
   assign match   = (cnt_inc == period_i);
   assign hit_o   = en_i & match;
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (en_i) begin
         cnt_q <= match ? '0 : cnt_inc;
      end
   end

endmodule

// File: rtl/env_curve_div.sv
module env_curve_div
   import env_shaper_pkg::*;
#(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rate_hit_i,
   input  logic             bypass_i,
   input  logic [LVL_W-1:0] lvl_i,
   output logic             step_o
);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_per;
   logic [DIV_W:0]   div_nxt;
   logic             due;

   assign div_per = DIV_W'(curve_period(lvl_i));
   assign div_nxt = {1'b0, div_q} + (DIV_W+1)'(1);
   assign due     = (div_nxt >= {1'b0, div_per});
   assign step_o  = rate_hit_i & (bypass_i | due);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (rate_hit_i) begin
         if (bypass_i || due) div_q <= '0;
         else                 div_q <= div_nxt[DIV_W-1:0];
      end
   end

endmodule

// File: rtl/env_stepper.sv
module env_stepper
   import env_shaper_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             gate_i,
   input  logic             step_i,
   input  logic [3:0]       sus_i,
   output logic [LVL_W-1:0] lvl_o,
   output stage_e           stage_o
);

   logic [LVL_W-1:0] lvl_q, lvl_d, target;
   stage_e           stage_q, stage_d;
   logic             gate_q, rise, fall;

   assign target = {sus_i, sus_i};
   assign rise   = gate_i & ~gate_q;
   assign fall   = ~gate_i & gate_q;

   always_comb begin
      lvl_d   = lvl_q;
      stage_d = stage_q;
      unique case (stage_q)
         STG_ATTACK: begin
            if (lvl_q == 8'hFF) begin
               stage_d = STG_DECAY;
            end else if (step_i) begin
               lvl_d = lvl_q + 8'd1;
               if (lvl_q == 8'hFE) stage_d = STG_DECAY;
            end
         end
         STG_DECAY: begin
            if (step_i && lvl_q != target && lvl_q != 8'h00) lvl_d = lvl_q - 8'd1;
         end
         default: begin
            if (step_i && lvl_q != 8'h00) lvl_d = lvl_q - 8'd1;
         end
      endcase
      if (rise)      stage_d = STG_ATTACK;
      else if (fall) stage_d = STG_RELEASE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q   <= '0;
         stage_q <= STG_RELEASE;
         gate_q  <= 1'b0;
      end else if (en_i) begin
         lvl_q   <= lvl_d;
         stage_q <= stage_d;
         gate_q  <= gate_i;
      end
   end

   assign lvl_o   = lvl_q;
   assign stage_o = stage_q;

endmodule

// File: rtl/env_shaper.sv
module env_shaper
   import env_shaper_pkg::*;
#(
   parameter int CNT_W = 15,
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             gate,
   input  logic [3:0]       atk_rate,
   input  logic [3:0]       dcy_rate,
   input  logic [3:0]       sus_level,
   input  logic [3:0]       rel_rate,
   output logic [LVL_W-1:0] env_o
);

   localparam int PAD_W = CNT_W - RATE_MIN_W;

   generate
      if (CNT_W < RATE_MIN_W) begin : g_bad_cnt
         $error("CNT_W too narrow for the slowest rate period");
      end
      if (DIV_W < CURVE_MIN_W) begin : g_bad_div
         $error("DIV_W too narrow for the longest curve period");
      end
   endgenerate

   stage_e           stage;
   logic [3:0]       rate_sel;
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] rate_cnt;
   logic             rate_hit;
   logic             step;

   always_comb begin
      unique case (stage)
         STG_ATTACK: rate_sel = atk_rate;
         STG_DECAY:  rate_sel = dcy_rate;
         default:    rate_sel = rel_rate;
      endcase
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign period = {{PAD_W{1'b0}}, rate_period(rate_sel)};
      end else begin : g_exact
         assign period = rate_period(rate_sel);
      end
   endgenerate

   env_rate_div #(.CNT_W(CNT_W)) u_rate (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (tick_en),
      .period_i(period),
      .hit_o   (rate_hit),
      .cnt_o   (rate_cnt)
   );

   env_curve_div #(.DIV_W(DIV_W)) u_curve (
      .clk       (clk),
      .rst_n     (rst_n),
      .rate_hit_i(rate_hit),
      .bypass_i  (stage == STG_ATTACK),
      .lvl_i     (env_o),
      .step_o    (step)
   );

   env_stepper u_step (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (tick_en),
      .gate_i (gate),
      .step_i (step),
      .sus_i  (sus_level),
      .lvl_o  (env_o),
      .stage_o(stage)
   );

endmodule

// File: rtl/env_shaper_chk.sv
module env_shaper_chk #(
   parameter int CNT_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             gate,
   input logic [3:0]       sus_level,
   input logic [7:0]       env,
   input logic [1:0]       stage,
   input logic [CNT_W-1:0] rate_cnt,
   input logic             rate_hit
);

   // R11: nothing moves while the enable is low
   p_hold_env_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(env));
   p_hold_cnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(rate_cnt) && $stable(stage));

   // R3: without a match the counter climbs by one, wrapping at the top
   p_cnt_climb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en && !rate_hit |=> rate_cnt == CNT_W'($past(rate_cnt) + CNT_W'(1)));

   // R2: a match restarts the count
   p_cnt_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en && rate_hit |=> rate_cnt == '0);

   // R5: attack moves by at most one unit upward
   p_attack_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stage == 2'd0 && env != 8'hFF |=> env == $past(env) || env == 8'($past(env) + 8'd1));

   // R6: top of attack hands over to decay
   p_top_decay_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en && stage == 2'd0 && env == 8'hFF && gate |=> stage == 2'd1);

   // R8: sustain level is held while gate is high
   p_sustain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en && stage == 2'd1 && gate && env == {sus_level, sus_level} |=> $stable(env));

   // R10: zero is a floor outside attack
   p_zero_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stage != 2'd0 && env == 8'h00 && !gate |=> env == 8'h00);

endmodule

bind env_shaper env_shaper_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .gate     (gate),
   .sus_level(sus_level),
   .env      (env_o),
   .stage    (stage),
   .rate_cnt (rate_cnt),
   .rate_hit (rate_hit)
);

// File: tb/env_shaper_bench.sv
module env_shaper_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic       gate = 1'b0;
   logic [3:0] atk_rate = 4'd0;
   logic [3:0] dcy_rate = 4'd0;
   logic [3:0] sus_level = 4'd8;
   logic [3:0] rel_rate = 4'd0;
   logic [7:0] env_o;

   int n_total = 0;
   int n_fail = 0;
   int mism = 0;

   always #10 clk = ~clk;

   env_shaper u_env_shaper (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
      .atk_rate(atk_rate), .dcy_rate(dcy_rate), .sus_level(sus_level),
      .rel_rate(rel_rate), .env_o(env_o)
   );

   // ---------------- reference model built from the requirements
   function automatic int ref_period(input int sel);
      int tbl[16] = '{9, 32, 63, 95, 149, 220, 267, 313, 392, 977, 1954,
                      3126, 3907, 11720, 19532, 31251};
      return tbl[sel];
   endfunction

   function automatic int ref_curve(input int lvl);
      if (lvl >= 94) return 1;
      if (lvl >= 54) return 2;
      if (lvl >= 26) return 4;
      if (lvl >= 14) return 8;
      if (lvl >= 6)  return 16;
      return 30;
   endfunction

   int m_cnt, m_div, m_env, m_st, m_gq;

   always @(posedge clk) begin
      int per, inc, nst, tgt;
      bit hit, stp;
      if (!rst_n) begin
         m_cnt = 0; m_div = 0; m_env = 0; m_st = 2; m_gq = 0;
      end else if (tick_en) begin
         per = ref_period(m_st == 0 ? int'(atk_rate) : m_st == 1 ? int'(dcy_rate) : int'(rel_rate));
         inc = (m_cnt + 1) % 32768;
         hit = (inc == per);
         m_cnt = hit ? 0 : inc;
         stp = 1'b0;
         if (hit) begin
            if (m_st == 0) begin
               stp = 1'b1; m_div = 0;
            end else if (m_div + 1 >= ref_curve(m_env)) begin
               stp = 1'b1; m_div = 0;
            end else begin
               m_div = m_div + 1;
            end
         end
         nst = m_st;
         tgt = int'(sus_level) * 17;
         if (m_st == 0) begin
            if (m_env == 255) nst = 1;
            else if (stp) begin
               m_env = m_env + 1;
               if (m_env == 255) nst = 1;
            end
         end else if (m_st == 1) begin
            if (stp && m_env != tgt && m_env != 0) m_env = m_env - 1;
         end else begin
            if (stp && m_env != 0) m_env = m_env - 1;
         end
         if (gate && m_gq == 0) nst = 0;
         else if (!gate && m_gq == 1) nst = 2;
         m_gq = int'(gate);
         m_st = nst;
      end
   end

   always @(negedge clk) begin
      if (rst_n && int'(env_o) != m_env) begin
         mism = mism + 1;
         if (mism <= 3) $display("model mismatch at %0t: dut=%0d model=%0d", $time, env_o, m_env);
      end
   end

   // ---------------- helpers
   task automatic chk(input string req, input int act, input int exp);
      n_total++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_gt(input string req, input int act, input int lim);
      n_total++;
      if (act <= lim) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected above %0d", req, act, lim);
      end
   endtask

   task automatic chk_lt(input string req, input int act, input int lim);
      n_total++;
      if (act >= lim) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected below %0d", req, act, lim);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_level(input int lvl, input int lim, output bit found);
      found = 1'b0;
      for (int i = 0; i < lim; i++) begin
         if (int'(env_o) == lvl) begin
            found = 1'b1;
            break;
         end
         @(negedge clk);
      end
   endtask

   // cycles from reaching lvl until the level next changes
   task automatic measure(input int lvl, input int lim, output int n);
      bit found;
      wait_level(lvl, lim, found);
      n = 0;
      if (!found) begin
         n = -1;
         return;
      end
      do begin
         @(negedge clk);
         n++;
      end while (int'(env_o) == lvl && n < lim);
   endtask

   // ---------------- scenarios
   task automatic t_reset;
      int m0;
      m0 = mism;
      cyc(3);
      chk("R1 level during reset", int'(env_o), 0);
      rst_n = 1'b1;
      cyc(100);
      chk("R1 level after reset, gate low", int'(env_o), 0);
      chk("R1 model", mism - m0, 0);
   endtask

   task automatic t_attack_sustain;
      int m0, n;
      bit f;
      m0 = mism;
      atk_rate = 4'd0; dcy_rate = 4'd0; sus_level = 4'd8;
      gate = 1'b1;
      measure(8'h10, 1000, n);
      chk("R5 attack interval at rate 0", n, 9);
      wait_level(8'hFF, 4000, f);
      chk("R6 attack reaches top", int'(f), 1);
      wait_level(8'hFE, 100, f);
      chk("R6 decay follows top", int'(f), 1);
      cyc(3000);
      chk("R8 decay stops at sustain", int'(env_o), 8'h88);
      cyc(1000);
      chk("R8 sustain held", int'(env_o), 8'h88);
      chk("R5 R6 R8 model", mism - m0, 0);
   endtask

   task automatic t_release_curve;
      int m0, n;
      bit f;
      m0 = mism;
      gate = 1'b0;
      measure(8'h80, 200, n);
      chk("R7 release interval top band", n, 9);
      measure(8'h40, 2000, n);
      chk("R7 release interval band 2", n, 18);
      measure(8'h03, 6000, n);
      chk("R7 release interval bottom band", n, 270);
      wait_level(0, 2000, f);
      cyc(500);
      chk("R10 level clamps at zero", int'(env_o), 0);
      chk("R7 R10 model", mism - m0, 0);
   endtask

   task automatic t_gate_flip;
      int m0, v;
      bit f;
      m0 = mism;
      atk_rate = 4'd0; rel_rate = 4'd0;
      gate = 1'b1;
      wait_level(8'h30, 1000, f);
      gate = 1'b0;
      v = int'(env_o);
      cyc(300);
      chk_lt("R9 falling gate enters release", int'(env_o), v);
      gate = 1'b1;
      v = int'(env_o);
      cyc(100);
      chk_gt("R9 rising gate enters attack", int'(env_o), v);
      gate = 1'b0;
      wait_level(0, 8000, f);
      chk("R10 release settles at zero", int'(f), 1);
      chk("R9 model", mism - m0, 0);
   endtask

   task automatic t_rate_table;
      int m0, n;
      bit f;
      m0 = mism;
      atk_rate = 4'd1;
      gate = 1'b1;
      measure(2, 400, n);
      chk("R2 attack interval rate 1", n, 32);
      gate = 1'b0;
      wait_level(0, 3000, f);
      atk_rate = 4'd15;
      gate = 1'b1;
      measure(1, 70000, n);
      chk("R2 attack interval rate 15", n, 31251);
      gate = 1'b0;
      wait_level(0, 1000, f);
      chk("R2 back to zero", int'(f), 1);
      chk("R2 model", mism - m0, 0);
   endtask

   task automatic t_wrap;
      int m0;
      bit f;
      m0 = mism;
      rel_rate = 4'd5;
      cyc(150);
      atk_rate = 4'd0; rel_rate = 4'd0;
      gate = 1'b1;
      cyc(32000);
      chk("R3 no step before counter wraps", int'(env_o), 0);
      cyc(1500);
      chk_gt("R3 steps resume after wrap", int'(env_o), 0);
      gate = 1'b0;
      wait_level(0, 12000, f);
      chk("R3 model", mism - m0, 0);
   endtask

   task automatic t_toggle;
      int m0;
      m0 = mism;
      atk_rate = 4'd2; rel_rate = 4'd2;
      for (int i = 0; i < 75; i++) begin
         gate = 1'b1;
         cyc(40);
         gate = 1'b0;
         cyc(40);
      end
      chk_gt("R4 fast gate toggling still builds level", int'(env_o), 0);
      chk("R4 model", mism - m0, 0);
   endtask

   task automatic t_enable;
      int m0, v;
      m0 = mism;
      atk_rate = 4'd1;
      gate = 1'b1;
      for (int i = 0; i < 600; i++) begin
         tick_en = (i % 3) != 0;
         cyc(1);
      end
      tick_en = 1'b0;
      v = int'(env_o);
      cyc(500);
      chk("R11 level frozen while disabled", int'(env_o), v);
      tick_en = 1'b1;
      cyc(300);
      chk_gt("R11 level moves once enabled", int'(env_o), v);
      chk("R11 model", mism - m0, 0);
   endtask

   initial begin
      t_reset();
      t_attack_sustain();
      t_release_curve();
      t_gate_flip();
      t_rate_table();
      t_wrap();
      t_toggle();
      t_enable();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule